// File: doc/BRIEF.md
# DMA Acknowledge Timeout Dummy-Cycle Generator

On an ISA-style host bus a DMA acknowledge is normally followed, a few hundred nanoseconds later, by a read or write command strobe. During a host write-verify pass the acknowledge can arrive with no command after it. A DMA-capable card only learns that it was acknowledged when a card-side DMA cycle happens, so in that case it would never see its acknowledge or its terminal count. This block watches the host acknowledge. It starts a clock counter when the acknowledge goes low. If neither command strobe falls before a programmed limit, it drives one synthetic read-type DMA cycle toward the card. The data returned by the card during that cycle is thrown away.

The limit comes from an 8-bit configuration code. The code is bit-reversed and then an offset of six is added, so the code 80h gives seven clocks and the code 20h gives ten. With a 25 MHz internal clock, 80h (280 ns) suits a motherboard whose acknowledge-to-command delay is at most 270 ns. A card that plugs into a slot fits better with 20h. Only one synthetic cycle is produced per acknowledge. The block rearms when the host acknowledge returns high.

Top module: `dack_watchdog`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `card_dack_n` and `card_rd_n` are high and `card_tc` and `busy` are low. Reset also loads the delay code with 80h.
- R2: The timeout limit in clocks is the 8-bit delay code with bit i moved to bit 7-i, plus 6. Take E0 as the first clock edge that samples `host_dack_n` low after it was high. The synthetic cycle's outputs change on edge E0+limit.
- R3: If `host_ior_n` or `host_iow_n` is sampled falling on any edge from E0+1 through E0+limit, no synthetic cycle is produced for that acknowledge. A fall on edge E0+limit counts as in time.
- R4: A synthetic cycle holds `card_dack_n` and `card_rd_n` low and `busy` high for exactly 4 clocks, then releases all three together.
- R5: While `busy` is high, `card_tc` equals `host_tc` as sampled on the previous edge. While `busy` is low, `card_tc` is low.
- R6: At most one synthetic cycle is produced while `host_dack_n` stays low. A new acknowledge after `host_dack_n` has gone high arms the block again.
- R7: A command strobe that falls after the synthetic cycle has started neither shortens that cycle nor starts another one.
- R8: If `host_dack_n` returns high before the limit is reached, no synthetic cycle is produced.
- R9: A clock edge with `cfg_wr` high loads `cfg_din` as the delay code. The new code sets the limit for the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| host_dack_n | input | 1 | Host DMA acknowledge, active low |
| host_ior_n | input | 1 | Host I/O read command, active low |
| host_iow_n | input | 1 | Host I/O write command, active low |
| host_tc | input | 1 | Host terminal count, active high |
| cfg_wr | input | 1 | Load strobe for the delay code |
| cfg_din | input | 8 | New delay code |
| card_dack_n | output | 1 | Card-side DMA acknowledge, active low |
| card_tc | output | 1 | Card-side terminal count |
| card_rd_n | output | 1 | Card-side read strobe, active low |
| busy | output | 1 | High while a synthetic cycle is driven |

## Verification
A counter that is off by one shows up directly as a synthetic cycle one edge early or one edge late relative to E0+limit. For that reason every code in the vector table is checked for its exact start edge. A bit-order slip in the code decode moves the start edge by many clocks, and a code whose reversed value is asymmetric exposes it. A state machine that fails to hold after the synthetic cycle ends shows a second `busy` rise within a few clocks while the acknowledge is still low. A pulse counter that is wrong appears as a strobe width other than 4 on the same acknowledge.

// File: rtl/dackwd_pkg.sv
package dackwd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DUMMY = 2'd2,
    ST_HOLD  = 2'd3
  } dw_state_e;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

endpackage

// File: rtl/dackwd_limit.sv
module dackwd_limit #(
  parameter int          CODE_W  = 8,
  parameter int          LIM_OFS = 6,
  parameter int          LIM_W   = 9,
  parameter logic [7:0]  CFG_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_din,
  output logic [LIM_W-1:0]  limit
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_rev;

  always_ff @(posedge clk) begin
    if (rst)         code_q <= CODE_W'(CFG_RST);
    else if (cfg_wr) code_q <= cfg_din;
  end

  // Reverse the bit order of the code, one bit per generate slice.
  for (genvar i = 0; i < CODE_W; i++) begin : g_rev
    assign code_rev[i] = code_q[CODE_W-1-i];
  end

  assign limit = LIM_W'(code_rev) + LIM_W'(LIM_OFS);
endmodule

// File: rtl/dackwd_edges.sv
module dackwd_edges (
  input  logic clk,
  input  logic rst,
  input  logic host_dack_n,
  input  logic host_ior_n,
  input  logic host_iow_n,
  output logic dack_fall,
  output logic cmd_fall
);
  logic dack_q, ior_q, iow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dack_q <= 1'b1;
      ior_q  <= 1'b1;
      iow_q  <= 1'b1;
    end else begin
      dack_q <= host_dack_n;
      ior_q  <= host_ior_n;
      iow_q  <= host_iow_n;
    end
  end

  assign dack_fall = dack_q & ~host_dack_n;
  assign cmd_fall  = (ior_q & ~host_ior_n) | (iow_q & ~host_iow_n);
endmodule

// File: rtl/dackwd_ctrl.sv
module dackwd_ctrl
  import dackwd_pkg::*;
#(
  parameter int LIM_W = 9,
  parameter int PULSE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_dack_n,
  input  logic             host_tc,
  input  logic             dack_fall,
  input  logic             cmd_fall,
  input  logic [LIM_W-1:0] limit,
  output logic             card_dack_n,
  output logic             card_rd_n,
  output logic             card_tc,
  output logic             busy
);
  localparam int PW = $clog2(PULSE) + 1;
  localparam logic [PW-1:0] P_LAST = PW'(PULSE - 1);

  dw_state_e        st_q, st_nx;
  logic [LIM_W-1:0] cnt_q, cnt_nx;
  logic [PW-1:0]    pc_q, pc_nx;

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    pc_nx  = pc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (dack_fall) begin
          st_nx  = ST_COUNT;
          cnt_nx = LIM_W'(1);
        end
      end
      ST_COUNT: begin
        if (host_dack_n)         st_nx = ST_IDLE;
        else if (cmd_fall)       st_nx = ST_HOLD;
        else if (cnt_q == limit) begin
          st_nx = ST_DUMMY;
          pc_nx = '0;
        end else                 cnt_nx = cnt_q + LIM_W'(1);
      end
      ST_DUMMY: begin
        if (pc_q == P_LAST) st_nx = ST_HOLD;
        else                pc_nx = pc_q + PW'(1);
      end
      ST_HOLD: begin
        if (host_dack_n) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      pc_q        <= '0;
      card_dack_n <= 1'b1;
      card_rd_n   <= 1'b1;
      card_tc     <= 1'b0;
      busy        <= 1'b0;
    end else begin
      st_q        <= st_nx;
      cnt_q       <= cnt_nx;
      pc_q        <= pc_nx;
      card_dack_n <= (st_nx != ST_DUMMY);
      card_rd_n   <= (st_nx != ST_DUMMY);
      card_tc     <= (st_nx == ST_DUMMY) & host_tc;
      busy        <= (st_nx == ST_DUMMY);
    end
  end
endmodule

// File: rtl/dack_watchdog.sv
module dack_watchdog #(
  parameter int          CODE_W  = 8,
  parameter int          LIM_OFS = 6,
  parameter int          PULSE   = 4,
  parameter logic [7:0]  CFG_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_dack_n,
  input  logic              host_ior_n,
  input  logic              host_iow_n,
  input  logic              host_tc,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_din,
  output logic              card_dack_n,
  output logic              card_tc,
  output logic              card_rd_n,
  output logic              busy
);
  localparam int LIM_W = $clog2((1 << CODE_W) + LIM_OFS + 1);

  logic [LIM_W-1:0] limit;
  logic             dack_fall, cmd_fall;

  dackwd_limit #(
    .CODE_W(CODE_W), .LIM_OFS(LIM_OFS), .LIM_W(LIM_W), .CFG_RST(CFG_RST)
  ) u_limit (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_din(cfg_din), .limit(limit)
  );

  dackwd_edges u_edges (
    .clk(clk), .rst(rst),
    .host_dack_n(host_dack_n), .host_ior_n(host_ior_n), .host_iow_n(host_iow_n),
    .dack_fall(dack_fall), .cmd_fall(cmd_fall)
  );

  dackwd_ctrl #(.LIM_W(LIM_W), .PULSE(PULSE)) u_ctrl (
    .clk(clk), .rst(rst),
    .host_dack_n(host_dack_n), .host_tc(host_tc),
    .dack_fall(dack_fall), .cmd_fall(cmd_fall), .limit(limit),
    .card_dack_n(card_dack_n), .card_rd_n(card_rd_n),
    .card_tc(card_tc), .busy(busy)
  );
endmodule

// File: rtl/dackwd_checker.sv
module dackwd_checker #(
  parameter int PULSE = 4
) (
  input logic clk,
  input logic rst,
  input logic host_dack_n,
  input logic host_tc,
  input logic card_dack_n,
  input logic card_rd_n,
  input logic card_tc,
  input logic busy
);
  int   run_len;
  logic used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= 0;
      used_q  <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 1 : 0;
      if (host_dack_n)           used_q <= 1'b0;
      else if (busy && run_len == PULSE - 1) used_q <= 1'b1;
    end
  end

  // R1: outputs idle on the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (card_dack_n && card_rd_n && !card_tc && !busy));

  // R4: card strobes track the busy window
  p_strobes_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!card_dack_n && !card_rd_n));
  p_idle_strobes_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (card_dack_n && card_rd_n));

  // R4: busy window never exceeds the pulse length
  p_pulse_len_r4: assert property (@(posedge clk) disable iff (rst)
    run_len <= PULSE);

  // R5: terminal count passes through only inside the window
  p_tc_follow_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (card_tc == $past(host_tc)));
  p_tc_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !card_tc);

  // R6: no second window within one acknowledge
  p_one_dummy_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !used_q);
endmodule

bind dack_watchdog dackwd_checker #(.PULSE(PULSE)) u_chk (
  .clk(clk), .rst(rst), .host_dack_n(host_dack_n), .host_tc(host_tc),
  .card_dack_n(card_dack_n), .card_rd_n(card_rd_n), .card_tc(card_tc),
  .busy(busy)
);

// File: tb/tb_dack_watchdog.sv
module tb_dack_watchdog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_dack_n = 1'b1, host_ior_n = 1'b1, host_iow_n = 1'b1;
  logic       host_tc = 1'b0, cfg_wr = 1'b0;
  logic [7:0] cfg_din = 8'h00;
  logic       card_dack_n, card_tc, card_rd_n, busy;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dack_watchdog dut (
    .clk(clk), .rst(rst), .host_dack_n(host_dack_n), .host_ior_n(host_ior_n),
    .host_iow_n(host_iow_n), .host_tc(host_tc), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
    .card_dack_n(card_dack_n), .card_tc(card_tc), .card_rd_n(card_rd_n), .busy(busy)
  );

  // code, command sample index (0 = none), use write strobe, expected first busy sample (0 = none)
  localparam int NV = 11;
  localparam logic [7:0] V_CODE [NV] = '{8'h80, 8'h40, 8'hC0, 8'h20, 8'hA0, 8'h60,
                                         8'h00, 8'hFF, 8'h80, 8'h80, 8'h80};
  localparam int V_CMD [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 3, 7, 8};
  localparam int V_EXP [NV] = '{8, 9, 10, 11, 12, 13, 7, 262, 0, 0, 8};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One acknowledge. Sample k is taken after k rising edges from the acknowledge drop.
  task automatic run_ack(input bit wr_cfg, input logic [7:0] code, input int cmd_at,
                         input bit use_iow, input bit tc, input int exp_start,
                         input string req);
    int first = 0, width = 0, rises = 0;
    bit prev = 1'b0, strobe_ok = 1'b1, tc_ok = 1'b1;
    if (wr_cfg) begin
      cfg_din = code; cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
    end
    host_tc = tc;
    host_dack_n = 1'b0;
    for (int k = 1; k <= 280; k++) begin
      @(negedge clk);
      if (busy && !prev) begin rises++; if (first == 0) first = k; end
      if (busy) width++;
      if (card_dack_n != !busy || card_rd_n != !busy) strobe_ok = 1'b0;
      if (card_tc != (busy & tc)) tc_ok = 1'b0;
      prev = busy;
      if (k == cmd_at) begin
        if (use_iow) host_iow_n = 1'b0; else host_ior_n = 1'b0;
      end
    end
    chk(first == exp_start, {req, " start"}, first, exp_start);
    chk(width == (exp_start != 0 ? 4 : 0), "R4 width", width, exp_start != 0 ? 4 : 0);
    chk(rises == (exp_start != 0 ? 1 : 0), "R6 single window", rises, exp_start != 0 ? 1 : 0);
    chk(strobe_ok, "R4 strobes match busy", int'(strobe_ok), 1);
    chk(tc_ok, "R5 terminal count", int'(tc_ok), 1);
    host_dack_n = 1'b1; host_ior_n = 1'b1; host_iow_n = 1'b1; host_tc = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(card_dack_n && card_rd_n && !card_tc && !busy, "R1 outputs during reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(card_dack_n && card_rd_n && !busy, "R1 outputs after reset", int'(busy), 0);

    // R1: default code 80h gives a limit of 7
    run_ack(1'b0, 8'h00, 0, 1'b0, 1'b1, 8, "R1 default code");

    // Vector table: R2 decode, R3 cancel and tie, R7 late strobe, R9 reload
    for (int v = 0; v < NV; v++)
      run_ack(1'b1, V_CODE[v], V_CMD[v], 1'b0, v[0], V_EXP[v],
              V_CMD[v] == 0 ? "R2/R9 decode" : (V_EXP[v] == 0 ? "R3 cancel" : "R7 late strobe"));

    // R3: write strobe cancels as well
    run_ack(1'b1, 8'h20, 5, 1'b1, 1'b0, 0, "R3 write strobe cancel");
    // R7: late write strobe during the window
    run_ack(1'b1, 8'h80, 9, 1'b1, 1'b1, 8, "R7 late write strobe");

    // R8: acknowledge withdrawn early, then rearm (R6)
    cfg_din = 8'h80; cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
    host_dack_n = 1'b0;
    repeat (3) @(negedge clk);
    host_dack_n = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (busy) seen++; end
      chk(seen == 0, "R8 early release", seen, 0);
    end
    run_ack(1'b0, 8'h00, 0, 1'b0, 1'b0, 8, "R6 rearm");

    // R1: reset in the middle of a window
    host_dack_n = 1'b0;
    repeat (9) @(negedge clk);
    chk(busy == 1'b1, "R1 window open before reset", int'(busy), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(card_dack_n && card_rd_n && !card_tc && !busy, "R1 reset mid window", int'(busy), 0);
    host_dack_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule